// File: doc/BRIEF.md
# Delayed Read and Posted Write Admission Queue

This block sits in the target side of a bus bridge and tracks the address and command of every request it agrees to take. For each incoming request it decides in one cycle whether to latch or refuse it. A latched write is posted: the master is finished with it, and the entry waits for the internal side to drain it. A latched read becomes a delayed read: the master is told to retry while the read is fetched internally. When the master comes back with the same address and command after the internal fetch has finished, the read completes and its entry is freed.

How many requests fit depends on the order in which they arrived. A read that lands in an empty queue leaves room for four posted writes behind it, so five entries can be held. When a write is the oldest entry the limit is four, whatever the mix. Only one delayed read is ever held, no more than four writes are ever posted, and a full write data buffer stops every new write. The internal side sees the oldest entry that still needs servicing and retires entries in arrival order with a completion strobe. The limits are checked again in every cycle against what the queue holds at that moment.

Top module: `adq_top`

## Requirements
- R1: After synchronous reset the queue holds nothing: `head_valid` is 0 and `rsp_valid` is 0.
- R2: A read (`req_cmd[0]`=0) that reaches an empty queue is latched and answered with code 1 (delayed). Four writes may then be posted behind it, for five entries in total. A fifth write is answered with code 2 (retry).
- R3: When the oldest held entry is a posted write, at most four entries are held in total. With one write queued ahead of a held read, a fourth write is refused while three writes and the read are held.
- R4: While four writes are posted, every read is answered with code 2 and is not latched. After one of those writes retires, a read is latched again.
- R5: While `wdata_full` is 1, a write (`req_cmd[0]`=1) is answered with code 2 and leaves the queue contents unchanged. A read is still admitted.
- R6: No more than four posted writes are ever held.
- R7: Only one delayed read is held at a time. A read with a different address or command is answered with code 2. A repeat of the held read before its internal completion is answered with code 2. A repeat after its internal completion is answered with code 3 (done) and frees the entry.
- R8: `head_addr`, `head_cmd` and `head_is_write` show the oldest entry that still needs internal service, in arrival order. A `head_done` pulse retires a write or marks a read as internally complete.
- R9: The limits follow the current contents. Once the write ahead of a read retires, the read becomes the oldest entry and the five-entry limit applies. A request in the same cycle as `head_done` is judged on the contents before that completion.
- R10: Every request cycle yields exactly one `rsp_valid` pulse in the next cycle. The pulse carries `rsp_code`: 0 posted, 1 delayed, 2 retry, 3 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 32 | Request address |
| req_cmd | input | 4 | Request command; bit 0 set means write |
| wdata_full | input | 1 | Write data buffer has no room |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 2 | 0 posted, 1 delayed, 2 retry, 3 done |
| head_valid | output | 1 | An entry awaits internal service |
| head_is_write | output | 1 | Head entry is a posted write |
| head_addr | output | 32 | Head entry address |
| head_cmd | output | 4 | Head entry command |
| head_done | input | 1 | Internal side finished the head entry |

## Verification
Admission of a new request and internal retirement of the head entry can fall in the same cycle. The bench fills the queue with four posted writes and then raises a read request and `head_done` together. It expects a retry, because the decision uses the contents before the retirement. In the following cycle it expects the same read to be latched as delayed, which shows that both updates took effect. It also checks that the five-entry limit opens up when a write queued ahead of the read retires.

// File: rtl/adq_pkg.sv
package adq_pkg;

    parameter int ADDR_W = 32;
    parameter int CMD_W  = 4;

    typedef enum logic [1:0] {
        RSP_POSTED  = 2'd0,
        RSP_DELAYED = 2'd1,
        RSP_RETRY   = 2'd2,
        RSP_DONE    = 2'd3
    } rsp_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } entry_t;

    function automatic logic cmd_is_write(input logic [CMD_W-1:0] cmd);
        return cmd[0];
    endfunction

endpackage

// File: rtl/adq_wr_fifo.sv
module adq_wr_fifo
    import adq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  entry_t        push_ent,
    input  logic          pop,
    output entry_t        front,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    entry_t        slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_ent;
                wr_ptr        <= step(wr_ptr);
            end
            if (pop) rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign front = slots[rd_ptr];

endmodule

// File: rtl/adq_rd_slot.sv
module adq_rd_slot
    import adq_pkg::*;
#(
    parameter int MAX_WR = 4,
    localparam int CW = $clog2(MAX_WR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  entry_t        load_ent,
    input  logic [CW-1:0] load_ahead,
    input  logic          dec_ahead,
    input  logic          mark_done,
    input  logic          release_slot,
    output logic          present,
    output logic          done,
    output entry_t        ent,
    output logic [CW-1:0] ahead
);
    always_ff @(posedge clk) begin
        if (rst) begin
            present <= 1'b0;
            done    <= 1'b0;
            ent     <= '0;
            ahead   <= '0;
        end else begin
            if (load) begin
                present <= 1'b1;
                done    <= 1'b0;
                ent     <= load_ent;
                ahead   <= load_ahead;
            end else begin
                if (release_slot) begin
                    present <= 1'b0;
                    done    <= 1'b0;
                end else if (mark_done) begin
                    done <= 1'b1;
                end
                if (dec_ahead) ahead <= ahead - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adq_admit.sv
module adq_admit
    import adq_pkg::*;
#(
    parameter int MAX_WR = 4,
    localparam int CW = $clog2(MAX_WR + 1)
) (
    input  logic          req_valid,
    input  entry_t        req_ent,
    input  logic          wdata_full,
    input  logic [CW-1:0] wr_cnt,
    input  logic          rd_present,
    input  logic          rd_oldest,
    input  logic          rd_done,
    input  entry_t        rd_ent,
    output rsp_e          code,
    output logic          push_wr,
    output logic          load_rd,
    output logic          free_rd
);
    localparam logic [CW-1:0] WR_LIM      = CW'(MAX_WR);
    localparam logic [CW-1:0] WR_LIM_WOLD = CW'(MAX_WR - 1);

    logic wr_room, wr_ok, is_repeat;

    always_comb begin
        // Write-first ordering leaves one slot fewer for writes when a read is held.
        wr_room   = (wr_cnt < WR_LIM) &&
                    (!rd_present || rd_oldest || (wr_cnt < WR_LIM_WOLD));
        wr_ok     = wr_room && !wdata_full;
        is_repeat = rd_present && (rd_ent == req_ent);
        code      = RSP_RETRY;
        push_wr   = 1'b0;
        load_rd   = 1'b0;
        free_rd   = 1'b0;
        if (cmd_is_write(req_ent.cmd)) begin
            if (wr_ok) begin
                code    = RSP_POSTED;
                push_wr = req_valid;
            end
        end else if (rd_present) begin
            if (is_repeat && rd_done) begin
                code    = RSP_DONE;
                free_rd = req_valid;
            end
        end else if (wr_cnt < WR_LIM) begin
            code    = RSP_DELAYED;
            load_rd = req_valid;
        end
    end
endmodule

// File: rtl/adq_top.sv
module adq_top
    import adq_pkg::*;
#(
    parameter int MAX_WR = 4,
    localparam int CW = $clog2(MAX_WR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic              wdata_full,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              head_valid,
    output logic              head_is_write,
    output logic [ADDR_W-1:0] head_addr,
    output logic [CMD_W-1:0]  head_cmd,
    input  logic              head_done
);
    entry_t        req_ent, wr_front, rd_ent;
    logic [CW-1:0] wr_cnt, rd_ahead, load_ahead;
    logic          rd_present, rd_done, rd_oldest, rd_at_head;
    logic          push_wr, load_rd, free_rd, pop_wr, mark_done, dec_ahead;
    rsp_e          code;

    assign req_ent = '{addr: req_addr, cmd: req_cmd};

    adq_wr_fifo #(.DEPTH(MAX_WR)) u_wr_fifo (
        .clk(clk), .rst(rst),
        .push(push_wr), .push_ent(req_ent),
        .pop(pop_wr), .front(wr_front), .count(wr_cnt)
    );

    adq_rd_slot #(.MAX_WR(MAX_WR)) u_rd_slot (
        .clk(clk), .rst(rst),
        .load(load_rd), .load_ent(req_ent), .load_ahead(load_ahead),
        .dec_ahead(dec_ahead), .mark_done(mark_done), .release_slot(free_rd),
        .present(rd_present), .done(rd_done), .ent(rd_ent), .ahead(rd_ahead)
    );

    adq_admit #(.MAX_WR(MAX_WR)) u_admit (
        .req_valid(req_valid), .req_ent(req_ent), .wdata_full(wdata_full),
        .wr_cnt(wr_cnt), .rd_present(rd_present), .rd_oldest(rd_oldest),
        .rd_done(rd_done), .rd_ent(rd_ent),
        .code(code), .push_wr(push_wr), .load_rd(load_rd), .free_rd(free_rd)
    );

    // Head selection: the held read is serviced once every write ahead of it has drained.
    always_comb begin
        rd_oldest  = rd_present && (rd_ahead == '0);
        rd_at_head = rd_oldest && !rd_done;
        pop_wr     = head_done && !rd_at_head && (wr_cnt != '0);
        mark_done  = head_done && rd_at_head;
        dec_ahead  = pop_wr && rd_present && (rd_ahead != '0);
        load_ahead = wr_cnt - CW'(pop_wr);
        head_valid    = rd_at_head || (wr_cnt != '0);
        head_is_write = !rd_at_head && (wr_cnt != '0);
        head_addr     = rd_at_head ? rd_ent.addr : wr_front.addr;
        head_cmd      = rd_at_head ? rd_ent.cmd  : wr_front.cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_POSTED;
        end else begin
            rsp_valid <= req_valid;
            rsp_code  <= req_valid ? code : RSP_POSTED;
        end
    end

endmodule

// File: rtl/adq_checker.sv
module adq_checker
    import adq_pkg::*;
#(
    parameter int MAX_WR = 4,
    localparam int CW = $clog2(MAX_WR + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [CMD_W-1:0] req_cmd,
    input logic             wdata_full,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic [CW-1:0]    wr_cnt,
    input logic             rd_present,
    input logic             rd_oldest
);
    AST_WR_LIMIT: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= CW'(MAX_WR)); // R6

    AST_WRITE_FIRST_CAP: assert property (@(posedge clk) disable iff (rst)
        (rd_present && !rd_oldest) |-> (wr_cnt <= CW'(MAX_WR - 1))); // R3

    AST_FULL_READ_RETRY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_cmd[0] && wr_cnt == CW'(MAX_WR) && !rd_present)
        |=> (rsp_valid && rsp_code == RSP_RETRY)); // R4

    AST_WDATA_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd[0] && wdata_full)
        |=> (rsp_valid && rsp_code == RSP_RETRY && $stable(wr_cnt))); // R5

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RSP_DELAYED) |-> !$past(rd_present)); // R7

    AST_RSP_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid))); // R10
endmodule

bind adq_top adq_checker #(.MAX_WR(MAX_WR)) u_adq_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .wdata_full(wdata_full), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .wr_cnt(wr_cnt), .rd_present(rd_present), .rd_oldest(rd_oldest)
);

// File: tb/adq_top_bench.sv
`timescale 1ns/1ps
module adq_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        wdata_full = 1'b0;
    logic        head_done = 1'b0;
    logic        rsp_valid, head_valid, head_is_write;
    logic [1:0]  rsp_code;
    logic [31:0] head_addr;
    logic [3:0]  head_cmd;

    localparam logic [3:0] RD = 4'h6, WR = 4'h7;
    localparam logic [1:0] C_POST = 2'd0, C_DLY = 2'd1, C_RTY = 2'd2, C_DONE = 2'd3;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [1:0] got;

    adq_top u_adq_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .wdata_full(wdata_full), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .head_valid(head_valid), .head_is_write(head_is_write),
        .head_addr(head_addr), .head_cmd(head_cmd), .head_done(head_done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; head_done = 1'b0; wdata_full = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One request; response sampled at the negedge after the latching edge.
    task automatic send(input logic [31:0] a, input logic [3:0] c, output logic [1:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        @(negedge clk);
        req_valid = 1'b0;
        if (rsp_valid !== 1'b1) begin
            n_bad++; n_chk++;
            $display("FAIL R10: act=rsp_valid %0b exp=1", rsp_valid);
        end
        r = rsp_code;
    endtask

    task automatic send_chk(input string tag, input logic [31:0] a, input logic [3:0] c,
                            input logic [1:0] exp);
        logic [1:0] r;
        send(a, c, r);
        check(tag, {30'd0, r}, {30'd0, exp});
    endtask

    task automatic retire();
        @(negedge clk);
        head_done = 1'b1;
        @(negedge clk);
        head_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 head_valid", {31'd0, head_valid}, 32'd0);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_read_first();
        do_reset();
        send_chk("R2 read into empty", 32'hA000, RD, C_DLY);
        for (int i = 0; i < 4; i++)
            send_chk("R2 write behind read", 32'h100 + i, WR, C_POST);
        send_chk("R2 fifth write refused", 32'h1FF, WR, C_RTY);
        send_chk("R7 second read", 32'hB000, RD, C_RTY);
        send_chk("R7 early repeat", 32'hA000, RD, C_RTY);
        check("R8 head is read", head_addr, 32'hA000);
        check("R8 head type", {31'd0, head_is_write}, 32'd0);
        retire();
        check("R8 next head", head_addr, 32'h100);
        send_chk("R7 repeat after completion", 32'hA000, RD, C_DONE);
        for (int i = 0; i < 4; i++) begin
            check("R8 drain order", head_addr, 32'h100 + i);
            retire();
        end
        check("R8 empty after drain", {31'd0, head_valid}, 32'd0);
    endtask

    task automatic t_write_first();
        do_reset();
        send_chk("R3 first write", 32'h200, WR, C_POST);
        send_chk("R3 read behind write", 32'hC000, RD, C_DLY);
        send_chk("R3 write 2", 32'h201, WR, C_POST);
        send_chk("R3 write 3", 32'h202, WR, C_POST);
        send_chk("R3 fourth write refused", 32'h203, WR, C_RTY);
        check("R8 head oldest write", head_addr, 32'h200);
        retire();
        check("R9 read now head", head_addr, 32'hC000);
        send_chk("R9 limit reopens", 32'h203, WR, C_POST);
        send_chk("R9 fifth entry", 32'h204, WR, C_POST);
        send_chk("R6 write limit", 32'h205, WR, C_RTY);
    endtask

    task automatic t_writes_full();
        do_reset();
        for (int i = 0; i < 4; i++)
            send_chk("R6 fill writes", 32'h300 + i, WR, C_POST);
        send_chk("R4 read with four writes", 32'hD000, RD, C_RTY);
        check("R4 read not latched", {31'd0, head_is_write}, 32'd1);
        retire();
        send_chk("R4 read after retire", 32'hD000, RD, C_DLY);
    endtask

    task automatic t_wdata_full();
        do_reset();
        wdata_full = 1'b1;
        send_chk("R5 write refused", 32'h400, WR, C_RTY);
        check("R5 queue unchanged", {31'd0, head_valid}, 32'd0);
        send_chk("R5 read admitted", 32'hE000, RD, C_DLY);
        wdata_full = 1'b0;
        send_chk("R5 write after release", 32'h401, WR, C_POST);
    endtask

    task automatic t_same_cycle();
        do_reset();
        for (int i = 0; i < 4; i++)
            send_chk("R9 fill", 32'h500 + i, WR, C_POST);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hF000; req_cmd = RD; head_done = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; head_done = 1'b0;
        check("R9 decided on prior contents", {30'd0, rsp_code}, {30'd0, C_RTY});
        check("R8 retire in same cycle", head_addr, 32'h501);
        @(negedge clk);
        check("R10 single strobe", {31'd0, rsp_valid}, 32'd0);
        send_chk("R9 read next cycle", 32'hF000, RD, C_DLY);
    endtask

    initial begin
        t_reset();
        t_read_first();
        t_write_first();
        t_writes_full();
        t_wdata_full();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule